// File: doc/BRIEF.md
# Credit-Gated Packet Turn-Taking Layer

This block sits between a user packet stream and a half-duplex link core that carries one packet at a time in alternating directions. Each received packet gets exactly one reply from the block. The reply is a user data packet when the partner has granted receive credit and the user has a packet waiting. Otherwise the reply is a single-word control packet with no body. Because of this rule, neither end of the link can stall it.

Packets are sequences of 32-bit words. A packet starts with one header word, and the body follows. Header bits [4:0] give the body length in words (0 to 31), and header bit [5] is the receive credit. A set credit bit tells the partner that the sender's receive side can take a full data packet. The block sets this bit in every header it sends from the local receive-ready input, sampled when that header is on the core port. The block swallows received header-only packets. It forwards received data packets, header included, to the user receive stream. The `IS_MASTER` parameter picks which end of the link sends first after reset.

Top module: `credit_turn_layer`

## Requirements
- R1: After reset the block offers no packet for one cycle. A master then offers a control packet. A slave instead waits to receive, with `crx_ready` high for a header-only word.
- R2: A control packet is one header word with bits [4:0] equal to 0. It is held on `ctx_data` with `ctx_valid` high until `ctx_ready` accepts it.
- R3: Bit [5] of every outgoing header, whether control or data, equals `urx_ready` in the cycle the header is offered. All other bits of a user data header pass through unchanged.
- R4: In the cycle after the last word of an outgoing packet is accepted, `ctx_valid` and `utx_ready` are low and the block is receiving.
- R5: When an incoming packet completes, the next outgoing packet is user data only if that packet's credit bit was 1 and `utx_valid` is high. In every other case the next outgoing packet is a control packet.
- R6: An incoming header with bits [4:0] equal to 0 is accepted whatever `urx_ready` is, and it never raises `urx_valid`.
- R7: An incoming data packet (header and body) is passed word by word to the user receive stream. `urx_valid` follows `crx_valid`, `crx_ready` follows `urx_ready`, and the length comes from the header's bits [4:0].
- R8: An outgoing user packet is passed word by word to the core. `utx_ready` follows `ctx_ready`, `ctx_valid` follows `utx_valid`, and the length comes from the header's bits [4:0].
- R9: The block never offers an outgoing word and accepts an incoming word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| utx_valid | input | 1 | User transmit word valid |
| utx_ready | output | 1 | User transmit word taken |
| utx_data | input | 32 | User transmit word |
| urx_valid | output | 1 | User receive word valid |
| urx_ready | input | 1 | User receive ready; also the source of the outgoing credit |
| urx_data | output | 32 | User receive word |
| ctx_valid | output | 1 | Word offered to the link core |
| ctx_ready | input | 1 | Link core takes the offered word |
| ctx_data | output | 32 | Word to the link core |
| crx_valid | input | 1 | Word from the link core valid |
| crx_ready | output | 1 | Block takes the incoming word |
| crx_data | input | 32 | Word from the link core |

## Verification
The bench targets the reply decision at three points: a header-only packet carrying no credit while user data is waiting, a credited packet, and a credited packet while the user has nothing to send. A design that decided from a stale credit value, or ignored `utx_valid`, would send data into a full partner or send an empty data packet. The bench also drives a bare incoming header while `urx_ready` is low. A design that forwarded such headers would stall the link or leak control tokens to the user. Finally, it checks the credit bit of each header against `urx_ready` in that cycle, and it stalls both streams in the middle of a packet to catch miscounted lengths.

// File: rtl/credit_turn_layer.sv
module credit_turn_layer #(
  parameter bit IS_MASTER = 1'b1,
  parameter int DW        = 32,
  parameter int SZ_W      = 5,
  parameter int CRED_POS  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          utx_valid,
  output logic          utx_ready,
  input  logic [DW-1:0] utx_data,
  output logic          urx_valid,
  input  logic          urx_ready,
  output logic [DW-1:0] urx_data,
  output logic          ctx_valid,
  input  logic          ctx_ready,
  output logic [DW-1:0] ctx_data,
  input  logic          crx_valid,
  output logic          crx_ready,
  input  logic [DW-1:0] crx_data
);

  typedef enum logic [1:0] {ST_IDLE, ST_META, ST_DATA, ST_RECV} st_t;

  st_t            st;
  logic           hdr_ph;
  logic [SZ_W-1:0] left;
  logic           cred_q;

  logic [SZ_W-1:0] rx_sz, tx_sz, cur_sz;
  logic           rx_bare, rx_fire, tx_fire, last, rx_cred;
  logic [DW-1:0]  meta_w, user_hdr;

  assign rx_sz   = crx_data[SZ_W-1:0];
  assign tx_sz   = utx_data[SZ_W-1:0];
  assign rx_bare = hdr_ph && (rx_sz == '0);

  assign crx_ready = (st == ST_RECV) && (rx_bare || urx_ready);
  assign urx_valid = (st == ST_RECV) && !rx_bare && crx_valid;
  assign urx_data  = crx_data;

  always_comb begin
    meta_w = '0;
    meta_w[CRED_POS] = urx_ready;
    user_hdr = utx_data;
    user_hdr[CRED_POS] = urx_ready;
  end

  assign ctx_valid = (st == ST_META) || ((st == ST_DATA) && utx_valid);
  assign ctx_data  = (st == ST_META) ? meta_w : (hdr_ph ? user_hdr : utx_data);
  assign utx_ready = (st == ST_DATA) && ctx_ready;

  assign rx_fire = crx_valid && crx_ready;
  assign tx_fire = ctx_valid && ctx_ready;
  assign cur_sz  = (st == ST_RECV) ? rx_sz : tx_sz;
  assign last    = hdr_ph ? (cur_sz == '0) : (left == SZ_W'(1));
  assign rx_cred = hdr_ph ? crx_data[CRED_POS] : cred_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      hdr_ph <= 1'b1;
      left   <= '0;
      cred_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: st <= IS_MASTER ? ST_META : ST_RECV;
        ST_META: if (ctx_ready) st <= ST_RECV;
        ST_DATA: if (tx_fire) begin
          if (last) begin
            st     <= ST_RECV;
            hdr_ph <= 1'b1;
          end else begin
            hdr_ph <= 1'b0;
            left   <= hdr_ph ? cur_sz : left - SZ_W'(1);
          end
        end
        ST_RECV: if (rx_fire) begin
          if (hdr_ph) cred_q <= crx_data[CRED_POS];
          if (last) begin
            hdr_ph <= 1'b1;
            st     <= (rx_cred && utx_valid) ? ST_DATA : ST_META;
          end else begin
            hdr_ph <= 1'b0;
            left   <= hdr_ph ? cur_sz : left - SZ_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctx_valid && crx_ready));

  // R2
  meta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_META && !ctx_ready) |=> (ctx_valid && ctx_data[SZ_W-1:0] == '0));

  // R4
  tx_to_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && last) |=> (!ctx_valid && !utx_ready));

  // R5
  data_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> cred_q);

  // R6
  bare_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECV && hdr_ph && crx_valid && rx_sz == '0) |-> (crx_ready && !urx_valid));

  // R7
  rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urx_valid |-> (crx_valid && (crx_ready == urx_ready)));

endmodule

// File: tb/credit_turn_layer_tb.sv
module credit_turn_layer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic utx_valid, utx_ready, urx_valid, urx_ready, ctx_valid, ctx_ready, crx_valid, crx_ready;
  logic [31:0] utx_data, urx_data, ctx_data, crx_data;
  logic s_utx_ready, s_urx_valid, s_ctx_valid, s_crx_ready;
  logic [31:0] s_urx_data, s_ctx_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  credit_turn_layer #(.IS_MASTER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .utx_valid(utx_valid), .utx_ready(utx_ready), .utx_data(utx_data),
    .urx_valid(urx_valid), .urx_ready(urx_ready), .urx_data(urx_data),
    .ctx_valid(ctx_valid), .ctx_ready(ctx_ready), .ctx_data(ctx_data),
    .crx_valid(crx_valid), .crx_ready(crx_ready), .crx_data(crx_data));

  credit_turn_layer #(.IS_MASTER(1'b0)) slave_i (
    .clk(clk), .rst_n(rst_n),
    .utx_valid(1'b0), .utx_ready(s_utx_ready), .utx_data(32'h0),
    .urx_valid(s_urx_valid), .urx_ready(1'b0), .urx_data(s_urx_data),
    .ctx_valid(s_ctx_valid), .ctx_ready(1'b0), .ctx_data(s_ctx_data),
    .crx_valid(1'b0), .crx_ready(s_crx_ready), .crx_data(32'h0));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  // R9 cycle monitor
  always @(negedge clk) if (rst_n && !done) begin
    if (ctx_valid && crx_ready) eq("R9 overlap", 1, 0);
  end

  initial begin
    #1500000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    utx_valid = 0; utx_data = 0; urx_ready = 0; ctx_ready = 0; crx_valid = 0; crx_data = 0;
    repeat (3) nx();
    eq("R1 reset ctx_valid", ctx_valid, 0);
    eq("R1 reset urx_valid", urx_valid, 0);
    rst_n = 1; #1;
    eq("R1 idle cycle", ctx_valid, 0);
    nx(); #1;
    eq("R1 master offers", ctx_valid, 1);
    eq("R2 meta size", ctx_data[4:0], 0);
    eq("R3 meta credit low", ctx_data[5], 0);
    eq("R1 slave silent", s_ctx_valid, 0);
    eq("R1 slave receiving", s_crx_ready, 1);
    urx_ready = 1; #1;
    eq("R3 meta credit high", ctx_data, 32'h20);
    nx(); #1;
    eq("R2 meta held", ctx_valid, 1);
    ctx_ready = 1; nx(); #1;
    eq("R4 done tx", ctx_valid, 0);
    eq("R4 no utx_ready", utx_ready, 0);
    ctx_ready = 0;
    // bare header, no credit, user waiting
    utx_valid = 1; utx_data = 32'hABCD0002; urx_ready = 0;
    crx_valid = 1; crx_data = 32'h0; #1;
    eq("R6 bare accepted", crx_ready, 1);
    eq("R6 bare hidden", urx_valid, 0);
    nx(); crx_valid = 0; ctx_ready = 1; #1;
    eq("R5 meta without credit", ctx_valid, 1);
    eq("R5 meta size", ctx_data[4:0], 0);
    eq("R5 user held", utx_ready, 0);
    nx(); ctx_ready = 0;
    // bare header with credit
    crx_valid = 1; crx_data = 32'h20; #1;
    eq("R6 credited bare accepted", crx_ready, 1);
    nx(); crx_valid = 0; #1;
    eq("R5 data sent", ctx_valid, 1);
    eq("R3 data hdr credit low", ctx_data, 32'hABCD0002);
    urx_ready = 1; #1;
    eq("R3 data hdr credit high", ctx_data, 32'hABCD0022);
    eq("R8 stall", utx_ready, 0);
    ctx_ready = 1; #1;
    eq("R8 handshake", utx_ready, 1);
    nx(); utx_data = 32'h11111111; #1;
    eq("R8 body1", ctx_data, 32'h11111111);
    utx_valid = 0; #1;
    eq("R8 user gap", ctx_valid, 0);
    utx_valid = 1; nx(); utx_data = 32'h22222222; #1;
    eq("R8 body2", ctx_data, 32'h22222222);
    nx(); #1;
    eq("R4 after data", ctx_valid, 0);
    eq("R4 utx_ready low", utx_ready, 0);
    ctx_ready = 0; utx_data = 32'h00000001;
    // incoming data packet without credit
    urx_ready = 0; crx_valid = 1; crx_data = 32'h5A000002; #1;
    eq("R7 hdr forwarded", urx_valid, 1);
    eq("R7 backpressure", crx_ready, 0);
    nx(); #1;
    eq("R7 hdr held", urx_data, 32'h5A000002);
    urx_ready = 1; #1;
    eq("R7 ready follows", crx_ready, 1);
    nx(); crx_data = 32'h33333333; #1;
    eq("R7 body1", urx_data, 32'h33333333);
    nx(); crx_data = 32'h44444444; #1;
    eq("R7 body2", urx_valid, 1);
    nx(); crx_valid = 0; urx_ready = 0; #1;
    eq("R5 no credit meta", ctx_valid, 1);
    eq("R5 no credit size", ctx_data[4:0], 0);
    eq("R3 credit low", ctx_data[5], 0);
    ctx_ready = 1; nx(); ctx_ready = 0; utx_valid = 0;
    // credited data packet, user idle
    urx_ready = 1; crx_valid = 1; crx_data = 32'h00000021;
    nx(); crx_data = 32'h55555555; #1;
    eq("R7 body", urx_data, 32'h55555555);
    nx(); crx_valid = 0; #1;
    eq("R5 idle user meta", ctx_valid, 1);
    eq("R5 idle user meta word", ctx_data, 32'h20);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule